// File: doc/BRIEF.md
# Tearing-Effect Transfer Start Gate

This block decides the clock cycle in which a frame transfer to a command-mode panel may begin. Software or a sequencer arms it with a one-cycle `arm` pulse. The gate then returns a one-cycle `start_pulse` according to the selected trigger mode. In internal mode it starts right away. In the two tearing-effect modes it waits on the panel's tearing-effect output.

The panel sends its vertical and horizontal sync indications on one shared line. The gate synchronizes that line and measures how long each pulse lasts. Two programmed widths then separate vertical pulses from horizontal ones. In frame mode the transfer starts on a vertical pulse. In line mode the gate counts horizontal pulses after the most recent vertical pulse and releases the start when that count equals an 11-bit programmed line number. The block has no streaming data path. All of its pins are plain control and status signals.

Top module: `te_start_gate`

## Requirements
- R1: With `mode` = 0 (internal), an `arm` pulse sampled at one clock edge drives `start_pulse` high for exactly one cycle after that same edge.
- R2: `start_pulse` is low during and after reset. It never rises unless the gate is armed. After it fires, the gate disarms, so later sync events cause no start until `arm` is pulsed again.
- R3: A tearing-effect pulse shorter than `hs_width` clock cycles is ignored. It does not advance the line count and it does not trigger a start.
- R4: A pulse of at least `vs_width` cycles is a vertical sync. With `mode` = 1 (frame), an armed gate raises `start_pulse` on the third rising clock edge after the pulse's trailing edge on `te_in`.
- R5: A pulse of at least `hs_width` cycles but fewer than `vs_width` cycles is a horizontal sync. A horizontal sync never triggers a start in mode 1.
- R6: With `mode` = 2 (line), an armed gate starts when a horizontal sync brings the number of horizontal syncs since the last vertical sync up to `line_target`. A `line_target` of 0 starts on the vertical sync itself.
- R7: A vertical sync clears the horizontal-sync count to zero. Horizontal syncs that arrive before it therefore do not count toward `line_target`.
- R8: `vs_active_high` and `hs_active_high` select which level of `te_in` is measured for vertical and horizontal pulses: 1 means active high and 0 means active low.
- R9: `mode` = 3 is reserved and never produces a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 internal, 1 frame (vertical sync), 2 line count, 3 reserved |
| vs_active_high | input | 1 | Active level for vertical-pulse measurement |
| hs_active_high | input | 1 | Active level for horizontal-pulse measurement |
| vs_width | input | WIDTH_BITS | Minimum vertical-sync width in clock cycles |
| hs_width | input | WIDTH_BITS | Minimum horizontal-sync width in clock cycles |
| line_target | input | LINE_BITS | Horizontal-sync count that releases the start in line mode |
| arm | input | 1 | One-cycle request to arm a transfer start |
| te_in | input | 1 | Asynchronous tearing-effect line from the panel |
| start_pulse | output | 1 | One-cycle transfer start |

## Verification
The bench builds the block with its default parameters: 8-bit width counters and an 11-bit line target. It programs a vertical-sync width of 6 cycles and a horizontal-sync width of 3 cycles. These values make short pulse trains reach every boundary: 2-cycle pulses just below the horizontal threshold, 3-cycle pulses exactly at it, 5-cycle pulses just below the vertical threshold, and 6-cycle pulses exactly at it. They also keep line-mode targets small enough to reach through both match and miss cases, the reset of the line count by a vertical sync, and inverted polarity.

// File: rtl/te_gate_pkg.sv
package te_gate_pkg;
  typedef enum logic [1:0] {
    TRIG_INTERNAL = 2'd0,
    TRIG_FRAME    = 2'd1,
    TRIG_LINE     = 2'd2,
    TRIG_RESERVED = 2'd3
  } trig_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_CHANNELS = 2; // 0: vertical, 1: horizontal
endpackage

// File: rtl/te_sync.sv
module te_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/te_width_meter.sv
module te_width_meter #(
  parameter int unsigned WB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          te_s,
  input  logic          act_high,
  output logic          run_end,
  output logic [WB-1:0] run_len
);
  localparam logic [WB-1:0] LEN_MAX = '1;

  logic          active;
  logic          idle_seen;
  logic [WB-1:0] len_q;

  assign active = act_high ? te_s : ~te_s;

  // A run only counts after the line has been seen idle, so the level
  // left behind by reset is never mistaken for a pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_seen <= 1'b0;
      len_q     <= '0;
    end else begin
      if (!active) idle_seen <= 1'b1;
      if (!active)
        len_q <= '0;
      else if (idle_seen && len_q != LEN_MAX)
        len_q <= len_q + 1'b1;
    end
  end

  assign run_end = !active && (len_q != '0);
  assign run_len = len_q;
endmodule

// File: rtl/te_line_counter.sv
module te_line_counter #(
  parameter int unsigned LB = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vs_evt,
  input  logic        hs_evt,
  input  logic [LB-1:0] target,
  output logic [LB:0] line_cnt,
  output logic        line_hit
);
  localparam logic [LB:0] CNT_MAX = '1;

  logic [LB:0] next_cnt;

  assign next_cnt = (line_cnt == CNT_MAX) ? line_cnt : line_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_cnt <= '0;
    else if (vs_evt) line_cnt <= '0;
    else if (hs_evt) line_cnt <= next_cnt;
  end

  assign line_hit = (hs_evt && next_cnt == {1'b0, target}) ||
                    (vs_evt && target == '0);
endmodule

// File: rtl/te_start_gate.sv
module te_start_gate
  import te_gate_pkg::*;
#(
  parameter int unsigned WIDTH_BITS = 8,
  parameter int unsigned LINE_BITS  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic                  vs_active_high,
  input  logic                  hs_active_high,
  input  logic [WIDTH_BITS-1:0] vs_width,
  input  logic [WIDTH_BITS-1:0] hs_width,
  input  logic [LINE_BITS-1:0]  line_target,
  input  logic                  arm,
  input  logic                  te_in,
  output logic                  start_pulse
);
  logic te_s;
  logic [NUM_CHANNELS-1:0] pol;
  logic [NUM_CHANNELS-1:0] ch_end;
  logic [WIDTH_BITS-1:0]   ch_len [NUM_CHANNELS];
  logic vs_evt, hs_evt, line_hit;
  logic [LINE_BITS:0] line_cnt;
  logic armed, pending, trigger, fire;
  trig_mode_e mode_e;

  te_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(te_in), .q_sync(te_s)
  );

  assign pol = {hs_active_high, vs_active_high};

  for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_meter
    te_width_meter #(.WB(WIDTH_BITS)) u_meter (
      .clk(clk), .rst_n(rst_n), .te_s(te_s), .act_high(pol[c]),
      .run_end(ch_end[c]), .run_len(ch_len[c])
    );
  end

  assign vs_evt = ch_end[0] && (ch_len[0] >= vs_width);
  assign hs_evt = ch_end[1] && (ch_len[1] >= hs_width) &&
                  (ch_len[1] < vs_width);

  te_line_counter #(.LB(LINE_BITS)) u_lines (
    .clk(clk), .rst_n(rst_n), .vs_evt(vs_evt), .hs_evt(hs_evt),
    .target(line_target), .line_cnt(line_cnt), .line_hit(line_hit)
  );

  assign mode_e  = trig_mode_e'(mode);
  assign pending = armed || arm;

  always_comb begin
    case (mode_e)
      TRIG_INTERNAL: trigger = 1'b1;
      TRIG_FRAME:    trigger = vs_evt;
      TRIG_LINE:     trigger = line_hit;
      default:       trigger = 1'b0;
    endcase
  end

  assign fire = pending && trigger;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      armed       <= pending && !fire;
      start_pulse <= fire;
    end
  end
endmodule

// File: rtl/te_start_gate_chk.sv
module te_start_gate_chk #(
  parameter int unsigned LB = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        arm,
  input logic [1:0]  mode,
  input logic        start_pulse,
  input logic        armed,
  input logic        vs_evt,
  input logic        hs_evt,
  input logic [LB:0] line_cnt
);
  // R1
  internal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && mode == 2'd0) |=> start_pulse);

  // R2
  armed_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(arm) || $past(armed)));

  // R5
  sync_class_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vs_evt && hs_evt));

  // R7
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_evt |=> (line_cnt == '0));

  // R9
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(mode) != 2'd3));
endmodule

bind te_start_gate te_start_gate_chk #(.LB(LINE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode),
  .start_pulse(start_pulse), .armed(armed), .vs_evt(vs_evt),
  .hs_evt(hs_evt), .line_cnt(line_cnt)
);

// File: tb/tb_te_start_gate.sv
module tb_te_start_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic vs_pol = 1'b1, hs_pol = 1'b1;
  logic [7:0] vs_w = 8'd6, hs_w = 8'd3;
  logic [10:0] tgt = '0;
  logic arm = 1'b0;
  logic te_in = 1'b0;
  logic start_pulse;

  int checks = 0, errors = 0, starts = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  te_start_gate dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .vs_active_high(vs_pol),
    .hs_active_high(hs_pol), .vs_width(vs_w), .hs_width(hs_w),
    .line_target(tgt), .arm(arm), .te_in(te_in), .start_pulse(start_pulse)
  );

  always @(negedge clk) if (rst_n && start_pulse) starts++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic p, input logic [10:0] t);
    @(negedge clk);
    rst_n = 1'b0; mode = m; vs_pol = p; hs_pol = p; tgt = t;
    te_in = ~p; arm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic te_pulse(input int len, input logic p);
    te_in = p;
    repeat (len) @(negedge clk);
    te_in = ~p;
    repeat (6) @(negedge clk);
  endtask

  // {mode[1:0], pol, target[10:0], 8 pulse codes x 2 bits, expected starts[1:0]}
  // pulse code: 0 none, 1 two-cycle glitch, 2 three-cycle hsync, 3 six-cycle vsync
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1, 1'b1, 11'd0, 16'b10_10_00_00_00_00_00_00, 2'd0}, // R5
    {2'd1, 1'b1, 11'd0, 16'b11_00_00_00_00_00_00_00, 2'd1}, // R4
    {2'd1, 1'b1, 11'd0, 16'b11_11_00_00_00_00_00_00, 2'd1}, // R2
    {2'd2, 1'b1, 11'd3, 16'b11_10_10_10_00_00_00_00, 2'd1}, // R6
    {2'd2, 1'b1, 11'd3, 16'b11_10_10_00_00_00_00_00, 2'd0}, // R6
    {2'd2, 1'b1, 11'd3, 16'b11_10_01_10_01_10_00_00, 2'd1}, // R3
    {2'd2, 1'b1, 11'd3, 16'b11_10_01_01_10_00_00_00, 2'd0}, // R3
    {2'd2, 1'b1, 11'd3, 16'b10_10_11_10_10_00_00_00, 2'd0}, // R7
    {2'd2, 1'b1, 11'd0, 16'b10_11_00_00_00_00_00_00, 2'd1}, // R6
    {2'd1, 1'b0, 11'd0, 16'b11_00_00_00_00_00_00_00, 2'd1}, // R8
    {2'd2, 1'b0, 11'd2, 16'b11_10_10_00_00_00_00_00, 2'd1}, // R8
    {2'd3, 1'b1, 11'd0, 16'b11_10_00_00_00_00_00_00, 2'd0}  // R9
  };
  localparam string VREQ [NV] = '{"R5","R4","R2","R6","R6","R3","R3","R7","R6","R8","R8","R9"};

  initial begin
    fork
      begin
        // R2: reset state
        @(negedge clk);
        check("R2", start_pulse, 0);
        do_reset(2'd0, 1'b1, 11'd0);
        check("R2", start_pulse, 0);

        // R1: internal mode starts one cycle after arm
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check("R1", start_pulse, 1);
        @(negedge clk);
        check("R1", start_pulse, 0);

        // R4: exact latency from vsync trailing edge
        do_reset(2'd1, 1'b1, 11'd0);
        do_arm();
        te_in = 1'b1;
        repeat (6) @(negedge clk);
        te_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R4", start_pulse, 0);
        @(negedge clk);
        check("R4", start_pulse, 1);
        @(negedge clk);
        check("R4", start_pulse, 0);

        // R5: five-cycle pulse counts as hsync in line mode, not as vsync
        do_reset(2'd2, 1'b1, 11'd1);
        do_arm();
        starts = 0;
        te_pulse(6, 1'b1);
        te_pulse(5, 1'b1);
        check("R5", starts, 1);
        do_reset(2'd1, 1'b1, 11'd0);
        do_arm();
        starts = 0;
        te_pulse(5, 1'b1);
        check("R5", starts, 0);

        // R2: no arm, no start
        do_reset(2'd1, 1'b1, 11'd0);
        starts = 0;
        te_pulse(6, 1'b1);
        check("R2", starts, 0);

        for (int i = 0; i < NV; i++) begin
          logic [31:0] v;
          v = VEC[i];
          do_reset(v[31:30], v[29], v[28:18]);
          do_arm();
          starts = 0;
          for (int k = 7; k >= 0; k--) begin
            case (v[2*k+2 +: 2])
              2'd1: te_pulse(2, v[29]);
              2'd2: te_pulse(3, v[29]);
              2'd3: te_pulse(6, v[29]);
              default: ;
            endcase
          end
          repeat (6) @(negedge clk);
          check(VREQ[i], starts, int'(v[1:0]));
        end
        done = 1'b1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule